// File: doc/BRIEF.md
# Display Controller Command Decoder

This block sits behind the host bus front end of a dot-matrix display controller. Each time the front end sees a command-register byte, it raises a one-cycle command strobe with the byte beside it. The decoder turns that byte into updates of the controller's control registers: display output enable, the RAM line scanned first, the current page, the current column, the all-points-lit override and the power-save flag. A separate data-write strobe marks each display data byte the host writes, and the column pointer steps after each one.

The register values leave the block as plain outputs. They feed the display RAM address path and the scan logic. Power-save has no opcode of its own. It is entered when the display is switched off while the all-points-lit override is already on, and it is left when the display is switched on or the override is cleared. Bytes that match no known command are dropped. A page value above the last valid page is also dropped.

Top module: `disp_cmd_decoder`

## Requirements
- R1: After reset every output is 0: display off, start line 0, page 0, column 0, all-points off, power-save off.
- R2: Byte 0xAF sets the display-enable output and clears power-save. Byte 0xAE clears the display-enable output.
- R3: Byte 0xAE while all-points is on sets power-save. Byte 0xAE while all-points is off leaves power-save at 0.
- R4: Byte 0xA5 turns all-points on. Byte 0xA4 turns all-points off and clears power-save.
- R5: A byte in 0x40..0x7F loads the start-line output with the byte's low 6 bits (0..63).
- R6: A byte in 0xB0..0xB8 loads the page output with the byte's low 4 bits. Bytes 0xB9..0xBF leave the page unchanged.
- R7: A page command changes no output other than the page.
- R8: A byte in 0x10..0x1F loads column bits 7:4 with the byte's low 4 bits. A byte in 0x00..0x0F loads column bits 3:0 with the byte's low 4 bits. The other half of the column is kept.
- R9: Each data-write strobe raises the column by one. From 131 (the last column) or any higher value, it goes to 0.
- R10: When a column command and a data-write strobe come in the same cycle, the command's nibble is loaded and no increment happens. A data write that comes with any other command still increments.
- R11: Bytes outside the listed sets (for example 0x20, 0x80, 0xA6, 0xE2, 0xFF) change no output. With no command strobe, the command byte has no effect.
- R12: Every update appears on the outputs after the rising clock edge at which its strobe is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | One-cycle strobe: cmdByte holds a command byte |
| cmdByte | input | 8 | Command byte from the bus front end |
| dataWrite | input | 1 | One-cycle strobe: a display data byte was written |
| dispOn | output | 1 | Display output enable |
| startLine | output | 6 | RAM line shown at the top of the panel |
| pageAddr | output | 4 | Current page for host RAM accesses |
| colAddr | output | 8 | Current column for host RAM accesses |
| allPointsOn | output | 1 | All-points-lit override |
| powerSave | output | 1 | Power-save state |

## Verification
The column pointer can be written by a nibble command and stepped by a data write in the same cycle. The bench provokes this by raising both strobes together with bytes 0x05 and 0x1F: the loaded nibble must appear exactly and no increment may be seen. As a control case, it pairs a data write with a start-line command, where the line must load and the column must still step. The bench also checks the wrap from column 131, and a wrap from a value above 131 reached by nibble commands.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  localparam int ARG_W = 6;

  localparam logic [7:0] OP_DISP_OFF = 8'hAE;
  localparam logic [7:0] OP_DISP_ON  = 8'hAF;
  localparam logic [7:0] OP_AP_OFF   = 8'hA4;
  localparam logic [7:0] OP_AP_ON    = 8'hA5;

  // Strobes from the decoder to the register file, one bit per update kind.
  typedef struct packed {
    logic             dispOn;
    logic             dispOff;
    logic             apOn;
    logic             apOff;
    logic             line;
    logic             page;
    logic             colHi;
    logic             colLo;
    logic             colInc;
    logic [ARG_W-1:0] arg;
  } dcdStrobe_t;

endpackage

// File: rtl/dcd_ctrl.sv
module dcd_ctrl
  import dcd_pkg::*;
#(
  parameter int PAGE_MAX = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdByte,
  input  logic       dataWrite,
  output dcdStrobe_t strb
);

  logic isLine, isPage, isColHi, isColLo;

  always_comb begin
    isLine  = (cmdByte[7:6] == 2'b01);
    isPage  = (cmdByte[7:4] == 4'hB) && (int'(cmdByte[3:0]) <= PAGE_MAX);
    isColHi = (cmdByte[7:4] == 4'h1);
    isColLo = (cmdByte[7:4] == 4'h0);
  end

  always_comb begin
    strb     = '0;
    strb.arg = cmdByte[ARG_W-1:0];
    if (cmdValid) begin
      if (cmdByte == OP_DISP_ON)       strb.dispOn  = 1'b1;
      else if (cmdByte == OP_DISP_OFF) strb.dispOff = 1'b1;
      else if (cmdByte == OP_AP_ON)    strb.apOn    = 1'b1;
      else if (cmdByte == OP_AP_OFF)   strb.apOff   = 1'b1;
      else if (isLine)                 strb.line    = 1'b1;
      else if (isPage)                 strb.page    = 1'b1;
      else if (isColHi)                strb.colHi   = 1'b1;
      else if (isColLo)                strb.colLo   = 1'b1;
    end
    // A column load in the same cycle takes priority over the step.
    strb.colInc = dataWrite && !strb.colHi && !strb.colLo;
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.dispOn, strb.dispOff, strb.apOn, strb.apOff,
              strb.line, strb.page, strb.colHi, strb.colLo})); // R11

  AST_NO_CMD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> !(strb.dispOn || strb.dispOff || strb.apOn || strb.apOff ||
                    strb.line || strb.page || strb.colHi || strb.colLo)); // R11

endmodule

// File: rtl/dcd_regs.sv
module dcd_regs
  import dcd_pkg::*;
#(
  parameter int LINE_W   = 6,
  parameter int PAGE_W   = 4,
  parameter int PAGE_MAX = 8,
  parameter int COL_W    = 8,
  parameter int COL_MAX  = 131
) (
  input  logic              clk,
  input  logic              rstN,
  input  dcdStrobe_t        strb,
  output logic              dispOn,
  output logic [LINE_W-1:0] startLine,
  output logic [PAGE_W-1:0] pageAddr,
  output logic [COL_W-1:0]  colAddr,
  output logic              allPointsOn,
  output logic              powerSave
);

  localparam int NIB = 4;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COL_MAX);

  logic [COL_W-1:0] colStep;

  generate
    if (COL_MAX == (1 << COL_W) - 1) begin : g_natWrap
      always_comb colStep = colAddr + 1'b1;
    end else begin : g_cmpWrap
      always_comb colStep = (colAddr >= COL_LAST) ? '0 : colAddr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispOn      <= 1'b0;
      startLine   <= '0;
      pageAddr    <= '0;
      colAddr     <= '0;
      allPointsOn <= 1'b0;
      powerSave   <= 1'b0;
    end else begin
      if (strb.dispOn) begin
        dispOn    <= 1'b1;
        powerSave <= 1'b0;
      end
      if (strb.dispOff) begin
        dispOn <= 1'b0;
        if (allPointsOn) powerSave <= 1'b1;
      end
      if (strb.apOn) allPointsOn <= 1'b1;
      if (strb.apOff) begin
        allPointsOn <= 1'b0;
        powerSave   <= 1'b0;
      end
      if (strb.line) startLine <= strb.arg[LINE_W-1:0];
      if (strb.page) pageAddr  <= strb.arg[PAGE_W-1:0];
      if (strb.colHi)       colAddr[2*NIB-1:NIB] <= strb.arg[NIB-1:0];
      else if (strb.colLo)  colAddr[NIB-1:0]     <= strb.arg[NIB-1:0];
      else if (strb.colInc) colAddr              <= colStep;
    end
  end

  AST_PS_NEEDS_AP: assert property (@(posedge clk) disable iff (!rstN)
    powerSave |-> (allPointsOn && !dispOn)); // R3

  AST_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(pageAddr) <= PAGE_MAX); // R6

  AST_PAGE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.page && !strb.colInc) |=> ($stable(dispOn) && $stable(startLine) &&
      $stable(colAddr) && $stable(allPointsOn) && $stable(powerSave))); // R7

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.colInc |=> (colAddr == (($past(colAddr) >= COL_LAST) ? '0
                                 : $past(colAddr) + 1'b1))); // R9

  AST_ON_WAKES: assert property (@(posedge clk) disable iff (!rstN)
    strb.dispOn |=> (dispOn && !powerSave)); // R2

endmodule

// File: rtl/disp_cmd_decoder.sv
module disp_cmd_decoder
  import dcd_pkg::*;
#(
  parameter int LINE_W   = 6,
  parameter int PAGE_W   = 4,
  parameter int PAGE_MAX = 8,
  parameter int COL_W    = 8,
  parameter int COL_MAX  = 131
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdByte,
  input  logic              dataWrite,
  output logic              dispOn,
  output logic [LINE_W-1:0] startLine,
  output logic [PAGE_W-1:0] pageAddr,
  output logic [COL_W-1:0]  colAddr,
  output logic              allPointsOn,
  output logic              powerSave
);

  dcdStrobe_t strb;

  dcd_ctrl #(.PAGE_MAX(PAGE_MAX)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdByte   (cmdByte),
    .dataWrite (dataWrite),
    .strb      (strb)
  );

  dcd_regs #(
    .LINE_W   (LINE_W),
    .PAGE_W   (PAGE_W),
    .PAGE_MAX (PAGE_MAX),
    .COL_W    (COL_W),
    .COL_MAX  (COL_MAX)
  ) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .dispOn      (dispOn),
    .startLine   (startLine),
    .pageAddr    (pageAddr),
    .colAddr     (colAddr),
    .allPointsOn (allPointsOn),
    .powerSave   (powerSave)
  );

endmodule

// File: tb/sim_disp_cmd_decoder.sv
module sim_disp_cmd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cmdValid;
  logic [7:0] cmdByte;
  logic       dataWrite;
  logic       dispOn;
  logic [5:0] startLine;
  logic [3:0] pageAddr;
  logic [7:0] colAddr;
  logic       allPointsOn;
  logic       powerSave;

  int checks = 0;
  int errors = 0;

  // Packed view: {dispOn, startLine, pageAddr, colAddr, allPointsOn, powerSave}
  logic [20:0] expQ[$];
  string       reqQ[$];

  logic       mDisp, mAp, mPs;
  logic [5:0] mLine;
  logic [3:0] mPage;
  logic [7:0] mCol;

  disp_cmd_decoder u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .dataWrite(dataWrite), .dispOn(dispOn), .startLine(startLine),
    .pageAddr(pageAddr), .colAddr(colAddr), .allPointsOn(allPointsOn),
    .powerSave(powerSave)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [20:0] actual();
    return {dispOn, startLine, pageAddr, colAddr, allPointsOn, powerSave};
  endfunction

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Driver: applies one strobe cycle, updates the model, pushes the result.
  task automatic step(input logic v, input logic [7:0] b, input logic dw,
                      input string req);
    logic colCmd;
    @(negedge clk);
    cmdValid  = v;
    cmdByte   = b;
    dataWrite = dw;
    colCmd    = v && (b[7:5] == 3'b000);
    if (v) begin
      if (b == 8'hAF) begin mDisp = 1'b1; mPs = 1'b0; end
      else if (b == 8'hAE) begin mDisp = 1'b0; if (mAp) mPs = 1'b1; end
      else if (b == 8'hA5) mAp = 1'b1;
      else if (b == 8'hA4) begin mAp = 1'b0; mPs = 1'b0; end
      else if (b >= 8'h40 && b <= 8'h7F) mLine = b[5:0];
      else if (b >= 8'hB0 && b <= 8'hB8) mPage = b[3:0];
      else if (b >= 8'h10 && b <= 8'h1F) mCol[7:4] = b[3:0];
      else if (b <= 8'h0F) mCol[3:0] = b[3:0];
    end
    if (dw && !colCmd) mCol = (mCol >= 8'd131) ? 8'd0 : mCol + 8'd1;
    @(posedge clk);
    #1;
    expQ.push_back({mDisp, mLine, mPage, mCol, mAp, mPs});
    reqQ.push_back(req);
    cmdValid  = 1'b0;
    dataWrite = 1'b0;
  endtask

  // Monitor: compares each expected item one half-cycle after its edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [20:0] e;
      string r;
      e = expQ.pop_front();
      r = reqQ.pop_front();
      checks++;
      if (actual() !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", r, actual(), e);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdByte = 8'h00; dataWrite = 1'b0;
    mDisp = 1'b0; mAp = 1'b0; mPs = 1'b0; mLine = '0; mPage = '0; mCol = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (actual() !== 21'd0) begin
      errors++;
      $display("FAIL R1: actual %h expected %h", actual(), 21'd0);
    end

    step(1, 8'hAF, 0, "R2 on");
    step(1, 8'hA5, 0, "R4 ap on");
    step(1, 8'hAE, 0, "R3 off with ap enters ps");
    step(1, 8'hAF, 0, "R2 on exits ps");
    step(1, 8'hAE, 0, "R3 ps again");
    step(1, 8'hA4, 0, "R4 ap off exits ps");
    step(1, 8'hAF, 0, "R2 on");
    step(1, 8'hAE, 0, "R3 off without ap no ps");

    step(1, 8'h40, 0, "R5 line 0");
    step(1, 8'h7F, 0, "R5 line 63");
    step(1, 8'h55, 0, "R5 line 21");

    step(1, 8'hB8, 0, "R6 page 8");
    step(1, 8'hB0, 0, "R6 page 0");
    step(1, 8'hB3, 0, "R6 page 3");
    step(1, 8'hB9, 0, "R6 page 9 ignored");
    step(1, 8'hBF, 0, "R6 page 15 ignored");
    step(1, 8'hA5, 0, "R4 ap on");
    step(1, 8'hAF, 0, "R2 on");
    step(1, 8'hB5, 0, "R7 page leaves others");

    step(1, 8'h18, 0, "R8 col hi");
    step(1, 8'h03, 0, "R8 col lo 131");
    step(0, 8'h00, 1, "R9 wrap at 131");
    step(1, 8'h02, 0, "R8 col lo");
    step(1, 8'h18, 0, "R8 col hi 130");
    step(0, 8'h00, 1, "R9 inc to 131");
    step(0, 8'h00, 1, "R9 wrap");
    step(0, 8'h00, 1, "R9 inc");
    step(1, 8'h1F, 0, "R8 col hi f");
    step(1, 8'h0F, 0, "R8 col 255");
    step(0, 8'h00, 1, "R9 wrap above max");

    step(1, 8'h05, 1, "R10 lo cmd beats write");
    step(1, 8'h1F, 1, "R10 hi cmd beats write");
    step(1, 8'h6A, 1, "R10 line cmd with write");

    step(1, 8'h20, 0, "R11 unknown 20");
    step(1, 8'h80, 0, "R11 unknown 80");
    step(1, 8'hA6, 0, "R11 unknown A6");
    step(1, 8'hE2, 0, "R11 unknown E2");
    step(1, 8'hFF, 0, "R11 unknown FF");
    step(0, 8'hAE, 0, "R11 no strobe");
    step(0, 8'h40, 0, "R11 no strobe line");
    step(1, 8'hAE, 0, "R12 off seen next edge");
    step(1, 8'h41, 1, "R12 line and step");

    repeat (3) @(negedge clk);
    report();
    $finish;
  end

endmodule